// File: doc/BRIEF.md
# Runtime-Variable Depth Delay Line over External Block RAM

The block delays a stream of samples by a number of valid samples that is chosen at runtime. It keeps the samples in an external simple dual-port block RAM. The block drives the write port and the read port of that RAM directly and takes the read data back. Each accepted sample is written at a write pointer. In the same cycle, the block reads the location that lies the programmed depth behind that pointer.

A depth word is sampled on every clock. Any change to it restarts fill tracking, so a sample that was stored before the change is never presented as valid unless the new depth makes it due. A depth of zero turns the block into a pass-through. The pass-through uses a register path with the same two-cycle latency as the RAM path. The block has one clock domain. Its reset is asserted asynchronously and released in step with the clock.

Top module: `var_delay_fifo`

## Requirements
- R1: While reset is active, and for two clocks after it is released, the RAM write strobe, write enable and read enable are low and `out_valid` is low. After reset the first accepted sample is written at address 0.
- R2: In a cycle with an accepted sample (`in_valid` high), the RAM write strobe and write enable are high, the write address equals the write pointer and the write data equals `in_data`. The pointer advances by one, modulo 2^ADDR_W, only after accepted samples.
- R3: In a cycle with an accepted sample, the read enable is high and the read address equals the write address minus the low ADDR_W bits of `depth`, modulo 2^ADDR_W. Without an accepted sample, both RAM enables are low.
- R4: A sample accepted in cycle t that is due for output shows `out_valid` high in cycle t+2. Gaps in `in_valid` reappear unchanged at the output.
- R5: With depth D > 0, the output of the k-th accepted sample carries the sample accepted D valid samples earlier.
- R6: After reset with depth D, the first D accepted samples produce no `out_valid`. Every later sample does.
- R7: A depth value that differs from the previous cycle's value restarts the fill count. This holds even in the same cycle as an accepted sample. Of the samples accepted from that cycle on, the first D' (the new depth) produce no `out_valid`.
- R8: With depth 0, every accepted sample appears unchanged on `out_data` with `out_valid` two cycles later.
- R9: A depth of 2^ADDR_W-1 delays the stream by that many samples while the pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the RAM |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| depth | input | 32 | Delay in valid samples; low ADDR_W bits used |
| in_data | input | DATA_W | Sample to delay |
| in_valid | input | 1 | Sample qualifier |
| out_data | output | DATA_W | Delayed sample |
| out_valid | output | 1 | Delayed sample qualifier |
| ram_wr_strobe | output | 1 | RAM write strobe |
| ram_wr_en | output | 1 | RAM write port enable |
| ram_wr_addr | output | ADDR_W | RAM write address |
| ram_wr_data | output | DATA_W | RAM write data |
| ram_rd_en | output | 1 | RAM read port enable |
| ram_rd_addr | output | ADDR_W | RAM read address |
| ram_rd_data | input | DATA_W | RAM read data, one cycle after the read |

## Verification
A depth change and an accepted sample can fall in the same cycle. The block must then clear the fill count and also judge that sample against the new depth. The bench provokes this by switching the depth in the very cycle it presents a sample. It also repeats the switch during a gap in `in_valid`. A reference model in the bench judges both cases. That model tracks the number of valid samples since the last change and predicts, sample by sample, which outputs must be valid and what they must carry.

// File: rtl/vdf_pkg.sv
package vdf_pkg;
  typedef enum logic {
    SRC_RAM    = 1'b0,
    SRC_BYPASS = 1'b1
  } vdf_src_e;
endpackage

// File: rtl/vdf_rst_sync.sv
module vdf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/vdf_ptr_ctrl.sv
module vdf_ptr_ctrl #(
  parameter int ADDR_W  = 13,
  parameter int DEPTH_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [DEPTH_W-1:0] depth,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               emit,
  output logic               bypass
);
  logic [DEPTH_W-1:0] depth_q;
  logic [ADDR_W-1:0]  wptr_q, wptr_d;
  logic [ADDR_W-1:0]  fill_q, fill_d, fill_eff;
  logic [ADDR_W-1:0]  d_eff;
  logic               changed, filled;

  // next-state
  always_comb begin
    d_eff    = depth[ADDR_W-1:0];
    changed  = (depth != depth_q);
    fill_eff = changed ? '0 : fill_q;
    filled   = (fill_eff >= d_eff);
    wptr_d   = wptr_q + 1'b1;
    fill_d   = fill_eff;
    if (accept && !filled) fill_d = fill_eff + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      wptr_q  <= '0;
      fill_q  <= '0;
    end else begin
      depth_q <= depth;
      fill_q  <= fill_d;
      if (accept) wptr_q <= wptr_d;
    end
  end

  assign wr_addr = wptr_q;
  assign rd_addr = wptr_q - d_eff;
  assign emit    = accept && filled;
  assign bypass  = (d_eff == '0);

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));
  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(wr_addr));
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !changed |-> fill_q <= d_eff);
  assert_fill_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> fill_q <= ADDR_W'(1));
endmodule

// File: rtl/vdf_out_pipe.sv
module vdf_out_pipe
  import vdf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              bypass,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] ram_rd_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic              v1_q;
  logic [DATA_W-1:0] byp_q;
  vdf_src_e          src_q, src_d;
  logic [DATA_W-1:0] out_d;
  logic [DATA_W-1:0] out_q;
  logic              ov_q;

  always_comb begin
    src_d = bypass ? SRC_BYPASS : SRC_RAM;
    out_d = (src_q == SRC_BYPASS) ? byp_q : ram_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      byp_q <= '0;
      src_q <= SRC_RAM;
      out_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      v1_q <= emit;
      ov_q <= v1_q;
      if (emit) begin
        byp_q <= in_data;
        src_q <= src_d;
      end
      if (v1_q) out_q <= out_d;
    end
  end

  assign out_data  = out_q;
  assign out_valid = ov_q;

  assert_stage_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(emit, 2));
endmodule

// File: rtl/var_delay_fifo.sv
module var_delay_fifo #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       depth,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              ram_wr_strobe,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic [DATA_W-1:0] ram_wr_data,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [DATA_W-1:0] ram_rd_data
);
  localparam int DEPTH_W = 32;

  logic run_n;
  logic accept;
  logic emit;
  logic bypass;

  vdf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (run_n)
  );

  assign accept = in_valid && run_n;

  vdf_ptr_ctrl #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_ptr (
    .clk     (clk),
    .rst_n   (run_n),
    .accept  (accept),
    .depth   (depth),
    .wr_addr (ram_wr_addr),
    .rd_addr (ram_rd_addr),
    .emit    (emit),
    .bypass  (bypass)
  );

  vdf_out_pipe #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (run_n),
    .emit        (emit),
    .bypass      (bypass),
    .in_data     (in_data),
    .ram_rd_data (ram_rd_data),
    .out_data    (out_data),
    .out_valid   (out_valid)
  );

  assign ram_wr_strobe = accept;
  assign ram_wr_en     = accept;
  assign ram_wr_data   = in_data;
  assign ram_rd_en     = accept;

  assert_ram_idle_R1: assert property (@(posedge clk)
    !run_n |-> !(ram_wr_en || ram_wr_strobe || ram_rd_en));
  assert_out_idle_R1: assert property (@(posedge clk)
    !run_n |-> !out_valid);
  assert_latency_R4: assert property (@(posedge clk) disable iff (!run_n)
    out_valid |-> $past(in_valid, 2));
  assert_rd_pair_R3: assert property (@(posedge clk)
    ram_rd_en == ram_wr_en);
endmodule

// File: tb/var_delay_fifo_bench.sv
module var_delay_fifo_bench;
  localparam int DW  = 16;
  localparam int AW  = 6;
  localparam int RAM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   depth;
  logic [DW-1:0] in_data;
  logic          in_valid;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          wr_strobe, wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] mem [RAM];

  int tests = 0;
  int fails = 0;

  // reference model state
  logic [DW-1:0] hist [RAM];
  int            n_acc;
  int            fill;
  logic [31:0]   dprev;
  logic          e1_v, e2_v;
  logic [DW-1:0] e1_d, e2_d;

  always #2 clk = ~clk;

  var_delay_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_var_delay_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .depth         (depth),
    .in_data       (in_data),
    .in_valid      (in_valid),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .ram_wr_strobe (wr_strobe),
    .ram_wr_en     (wr_en),
    .ram_wr_addr   (wr_addr),
    .ram_wr_data   (wr_data),
    .ram_rd_en     (rd_en),
    .ram_rd_addr   (rd_addr),
    .ram_rd_data   (rd_data)
  );

  always @(posedge clk) begin
    if (wr_en && wr_strobe) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_init();
    n_acc = 0; fill = 0; dprev = 0;
    e1_v = 1'b0; e2_v = 1'b0; e1_d = '0; e2_d = '0;
  endtask

  // one clock: check due output, drive inputs, check RAM ports, update model
  task automatic step(input logic v, input logic [DW-1:0] d, input logic [31:0] dep, input string req);
    logic [AW-1:0] deff;
    @(negedge clk);
    chk(out_valid === e2_v, {req, " out_valid"}, out_valid, e2_v);
    if (e2_v) chk(out_data === e2_d, {req, " out_data"}, out_data, e2_d);
    e2_v = e1_v; e2_d = e1_d;
    in_valid = v; in_data = d; depth = dep;
    #1;
    deff = dep[AW-1:0];
    if (dep != dprev) fill = 0;
    if (v) begin
      chk(wr_en === 1'b1 && wr_strobe === 1'b1, "R2 write enables", {wr_en, wr_strobe}, 3);
      chk(wr_addr === AW'(n_acc), "R2 write address", wr_addr, n_acc % RAM);
      chk(wr_data === d, "R2 write data", wr_data, d);
      chk(rd_en === 1'b1, "R3 read enable", rd_en, 1);
      chk(rd_addr === AW'(n_acc - int'(deff)), "R3 read address", rd_addr,
          (n_acc - int'(deff) + RAM) % RAM);
      e1_v = (fill >= int'(deff));
      e1_d = (deff == 0) ? d : hist[(n_acc - int'(deff) + RAM) % RAM];
      hist[n_acc % RAM] = d;
      n_acc++;
      if (fill < int'(deff)) fill++;
    end else begin
      chk(wr_en === 1'b0 && rd_en === 1'b0, "R3 idle enables", {wr_en, rd_en}, 0);
      e1_v = 1'b0;
    end
    dprev = dep;
  endtask

  task automatic flush(input logic [31:0] dep, input string req);
    for (int i = 0; i < 3; i++) step(1'b0, '0, dep, req);
  endtask

  // R1: reset holds RAM port quiet and output invalid
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b1; in_data = 16'hBEEF; depth = 32'd7;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(wr_en === 1'b0 && wr_strobe === 1'b0 && rd_en === 1'b0, "R1 ram quiet in reset",
          {wr_en, wr_strobe, rd_en}, 0);
      chk(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    end
    in_valid = 1'b0; depth = 32'd0;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 out_valid after release", out_valid, 0);
    end
    model_init();
  endtask

  // R8: bypass with depth zero
  task automatic t_bypass();
    for (int i = 0; i < 10; i++) step(1'b1, DW'(16'h1000 + i), 32'd0, "R8");
    flush(32'd0, "R8");
  endtask

  // R5, R6: continuous stream at depth 5
  task automatic t_fixed();
    for (int i = 0; i < 20; i++) step(1'b1, DW'(16'h2000 + i), 32'd5, "R5 R6");
    flush(32'd5, "R5");
  endtask

  // R4: gapped input at depth 3
  task automatic t_gapped();
    for (int i = 0; i < 24; i++) step((i % 3) != 0, DW'(16'h3000 + i), 32'd3, "R4");
    flush(32'd3, "R4");
  endtask

  // R7: depth change on a cycle carrying a sample, then during a gap
  task automatic t_change();
    for (int i = 0; i < 10; i++) step(1'b1, DW'(16'h4000 + i), 32'd3, "R7");
    for (int i = 0; i < 10; i++) step(1'b1, DW'(16'h4100 + i), 32'd2, "R7 same-cycle");
    step(1'b0, '0, 32'd4, "R7 idle change");
    for (int i = 0; i < 12; i++) step(1'b1, DW'(16'h4200 + i), 32'd4, "R7 after idle");
    for (int i = 0; i < 6; i++) step(1'b1, DW'(16'h4300 + i), 32'd0, "R7 to bypass");
    flush(32'd0, "R7");
  endtask

  // R9: largest depth with pointer wrap
  task automatic t_max();
    for (int i = 0; i < 150; i++) step(1'b1, DW'(16'h5000 + i), 32'(RAM - 1), "R9");
    flush(32'(RAM - 1), "R9");
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; depth = '0;
    model_init();
    t_reset();
    t_bypass();
    t_reset();
    t_fixed();
    t_gapped();
    t_change();
    t_max();
    t_reset();
    step(1'b1, 16'h6001, 32'd0, "R1 pointer after reset");
    flush(32'd0, "R1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule